// File: doc/BRIEF.md
# Hamming Syndrome Classifier and Byte Corrector

This block takes the parity code recomputed over a data chunk and the parity code read back from storage, and decides what went wrong between them. Each code is 22 bits wide: an 11-bit parity word in bits 10:0 and its companion parity word in bits 21:11. Each code covers one 256-byte chunk. The block XORs the two codes into a syndrome. It then sorts the result into one of four classes: clean, damage confined to the stored code, a single flipped data bit that can be repaired, or damage that cannot be repaired. For a repairable error it reports which byte and which bit failed.

A width input selects a 256-byte or a 512-byte sector. In the 512-byte case each 44-bit code input carries two codes: bits 21:0 cover bytes 0 to 255 and bits 43:22 cover bytes 256 to 511. The two halves are checked one after the other by a single classifier. Their error indications are ORed together. A repair in the upper half reports a byte index offset by 256.

A combinational read-modify port lets the caller stream data bytes past the block together with their byte index. The port returns each byte with the failing bit inverted when the index matches a pending repair, and returns every other byte unchanged.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: After reset, `done_o` is 0, both class outputs are 00, `err_o` is 0, the repair location outputs are 0 and `rmw_data_o` equals `rmw_data_i`.
- R2: A half is classed 00 (clean) when its syndrome is zero, or when its recomputed code is all zeros, or when its stored code is all zeros.
- R3: A syndrome with exactly one bit set is classed 01 (code-only error). It raises `err_o` and reports no repair location.
- R4: A syndrome that has exactly 11 bits set, and for which (calc[10:0]^calc[21:11]^stor[10:0]^stor[21:11]) equals 0x7FF, is classed 10 (corrected). In that case `err_o` stays 0. The byte index is syndrome bits 10:3 and the bit position is syndrome bits 2:0.
- R5: Every other nonzero syndrome between two nonzero codes is classed 11 (uncorrectable). It raises `err_o` and reports no repair location.
- R6: In 256-byte mode (`wide_i`=0), the results of a start pulse appear and `done_o` pulses for one cycle on the first clock edge after the start. `cls_hi_o` reads 00.
- R7: In 512-byte mode, the lower-half results appear one edge after the start and stay stable. The upper-half results and a one-cycle `done_o` appear on the second edge. The upper-half byte index is 256 plus syndrome bits 10:3. `err_o` is the OR of the two halves' error indications.
- R8: A start pulse that arrives while the upper half is being checked is ignored. Results and `done_o` still come from the earlier start.
- R9: On the read-modify port, when `rmw_idx_i` equals the byte index of a half classed 10, `rmw_data_o` is `rmw_data_i` with the reported bit inverted. For all other bytes `rmw_data_o` equals `rmw_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a check of the presented codes |
| wide_i | input | 1 | 1 selects 512-byte sectors (two codes) |
| calc_code_i | input | 44 | Recomputed codes, lower chunk in bits 21:0 |
| stor_code_i | input | 44 | Stored codes, lower chunk in bits 21:0 |
| done_o | output | 1 | One-cycle pulse when all halves are classified |
| cls_lo_o | output | 2 | Class of the lower chunk |
| cls_hi_o | output | 2 | Class of the upper chunk |
| err_o | output | 1 | OR of code-only and uncorrectable indications |
| fix_byte_lo_o | output | 9 | Failing byte index in the lower chunk, 0 if none |
| fix_bit_lo_o | output | 3 | Failing bit in the lower chunk, 0 if none |
| fix_byte_hi_o | output | 9 | Failing byte index in the upper chunk, 0 if none |
| fix_bit_hi_o | output | 3 | Failing bit in the upper chunk, 0 if none |
| rmw_idx_i | input | 9 | Index of the byte on the read-modify port |
| rmw_data_i | input | 8 | Byte to be repaired |
| rmw_data_o | output | 8 | Byte after repair |

## Verification
A narrow check has its class, location and done pulse due on the first clock edge after the start. In a wide check the lower half is due on that same first edge and the upper half plus done on the second edge. The bench drives each start on a falling edge and samples on the following falling edges: one edge later for narrow checks, one and two edges later for wide checks, with a further sample to confirm that done has dropped. The read-modify port is combinational from the stored results, so the bench sets an index and samples a short delay later, while no clock edge is pending.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN = 2'b00,
    CLS_CODE  = 2'b01,
    CLS_FIX   = 2'b10,
    CLS_BAD   = 2'b11
  } ecc_cls_e;
endpackage

// File: rtl/ecc_half_classify.sv
module ecc_half_classify
  import ecc_corr_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic [2*PW-1:0] calc_i,
  input  logic [2*PW-1:0] stor_i,
  output ecc_cls_e        cls_o,
  output logic [PW-1:0]   addr_o
);
  localparam int CW    = 2 * PW;
  localparam int CNT_W = $clog2(CW + 1);

  logic [CW-1:0]    syn;
  logic [CNT_W-1:0] ones;
  logic [PW-1:0]    pair_chk;

  always_comb begin
    syn  = calc_i ^ stor_i;
    ones = '0;
    for (int i = 0; i < CW; i++) begin
      ones = ones + CNT_W'(syn[i]);
    end
    pair_chk = calc_i[PW-1:0] ^ calc_i[CW-1:PW] ^ stor_i[PW-1:0] ^ stor_i[CW-1:PW];
  end

  always_comb begin
    addr_o = '0;
    if (syn == '0 || calc_i == '0 || stor_i == '0) begin
      cls_o = CLS_CLEAN;
    end else if (ones == CNT_W'(1)) begin
      cls_o = CLS_CODE;
    end else if (ones == CNT_W'(PW) && pair_chk == {PW{1'b1}}) begin
      cls_o  = CLS_FIX;
      addr_o = syn[PW-1:0];
    end else begin
      cls_o = CLS_BAD;
    end
  end
endmodule

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, busy_d;
  logic done_q, done_d;

  always_comb begin
    accept_o = start_i && !busy_q;
    busy_d   = accept_o && wide_i;
    done_d   = (accept_o && !wide_i) || busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_narrow_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q && !wide_i) |=> (done_q && !busy_q));

  assert_wide_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> done_q);

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> !busy_q);

  assert_wide_no_early_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q && wide_i) |=> !done_q);
endmodule

// File: rtl/ecc_byte_fix.sv
module ecc_byte_fix #(
  parameter int PW    = 11,
  parameter int BIT_W = 3
) (
  input  logic [PW-BIT_W:0]    idx_i,
  input  logic [2**BIT_W-1:0]  data_i,
  input  logic                 lo_valid_i,
  input  logic [PW-1:0]        lo_addr_i,
  input  logic                 hi_valid_i,
  input  logic [PW-1:0]        hi_addr_i,
  output logic [2**BIT_W-1:0]  data_o
);
  localparam int BYTE_BITS = PW - BIT_W;
  localparam int DW        = 2 ** BIT_W;

  logic [DW-1:0] mask;

  always_comb begin
    mask = '0;
    if (lo_valid_i && idx_i == {1'b0, lo_addr_i[PW-1:BIT_W]}) begin
      mask = mask | (DW'(1) << lo_addr_i[BIT_W-1:0]);
    end
    if (hi_valid_i && idx_i == {1'b1, hi_addr_i[PW-1:BIT_W]}) begin
      mask = mask | (DW'(1) << hi_addr_i[BIT_W-1:0]);
    end
    data_o = data_i ^ mask;
  end

  always_comb begin
    assert_single_flip_R9: assert ($countones(data_o ^ data_i) <= 1)
      else $error("more than one bit changed on the repair port");
  end

  logic unused_w;
  assign unused_w = ^BYTE_BITS;
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_corr_pkg::*;
#(
  parameter int PW    = 11,
  parameter int BIT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  wide_i,
  input  logic [4*PW-1:0]       calc_code_i,
  input  logic [4*PW-1:0]       stor_code_i,
  output logic                  done_o,
  output logic [1:0]            cls_lo_o,
  output logic [1:0]            cls_hi_o,
  output logic                  err_o,
  output logic [PW-BIT_W:0]     fix_byte_lo_o,
  output logic [BIT_W-1:0]      fix_bit_lo_o,
  output logic [PW-BIT_W:0]     fix_byte_hi_o,
  output logic [BIT_W-1:0]      fix_bit_hi_o,
  input  logic [PW-BIT_W:0]     rmw_idx_i,
  input  logic [2**BIT_W-1:0]   rmw_data_i,
  output logic [2**BIT_W-1:0]   rmw_data_o
);
  localparam int CW     = 2 * PW;
  localparam int BYTE_W = PW - BIT_W;

  logic accept, busy;

  ecc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .wide_i   (wide_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  // Upper-half codes held for the second check cycle
  logic [CW-1:0] hold_calc_q, hold_stor_q;
  logic [CW-1:0] cl_calc, cl_stor;
  ecc_cls_e      cl_cls;
  logic [PW-1:0] cl_addr;

  always_comb begin
    cl_calc = busy ? hold_calc_q : calc_code_i[CW-1:0];
    cl_stor = busy ? hold_stor_q : stor_code_i[CW-1:0];
  end

  ecc_half_classify #(.PW(PW)) u_cls (
    .calc_i (cl_calc),
    .stor_i (cl_stor),
    .cls_o  (cl_cls),
    .addr_o (cl_addr)
  );

  ecc_cls_e      cls_lo_q, cls_hi_q, cls_hi_d;
  logic [PW-1:0] addr_lo_q, addr_hi_q, addr_hi_d;
  logic          hi_en;

  always_comb begin
    hi_en     = accept || busy;
    cls_hi_d  = busy ? cl_cls : CLS_CLEAN;
    addr_hi_d = busy ? cl_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_calc_q <= '0;
      hold_stor_q <= '0;
      cls_lo_q    <= CLS_CLEAN;
      addr_lo_q   <= '0;
    end else if (accept) begin
      hold_calc_q <= calc_code_i[2*CW-1:CW];
      hold_stor_q <= stor_code_i[2*CW-1:CW];
      cls_lo_q    <= cl_cls;
      addr_lo_q   <= cl_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_hi_q  <= CLS_CLEAN;
      addr_hi_q <= '0;
    end else if (hi_en) begin
      cls_hi_q  <= cls_hi_d;
      addr_hi_q <= addr_hi_d;
    end
  end

  logic lo_fix, hi_fix;
  assign lo_fix = (cls_lo_q == CLS_FIX);
  assign hi_fix = (cls_hi_q == CLS_FIX);

  always_comb begin
    cls_lo_o      = cls_lo_q;
    cls_hi_o      = cls_hi_q;
    err_o         = (cls_lo_q == CLS_CODE) || (cls_lo_q == CLS_BAD) ||
                    (cls_hi_q == CLS_CODE) || (cls_hi_q == CLS_BAD);
    fix_byte_lo_o = lo_fix ? {1'b0, addr_lo_q[PW-1:BIT_W]} : '0;
    fix_bit_lo_o  = lo_fix ? addr_lo_q[BIT_W-1:0] : '0;
    fix_byte_hi_o = hi_fix ? {1'b1, addr_hi_q[PW-1:BIT_W]} : '0;
    fix_bit_hi_o  = hi_fix ? addr_hi_q[BIT_W-1:0] : '0;
  end

  ecc_byte_fix #(.PW(PW), .BIT_W(BIT_W)) u_fix (
    .idx_i      (rmw_idx_i),
    .data_i     (rmw_data_i),
    .lo_valid_i (lo_fix),
    .lo_addr_i  (addr_lo_q),
    .hi_valid_i (hi_fix),
    .hi_addr_i  (addr_hi_q),
    .data_o     (rmw_data_o)
  );

  assert_lo_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cls_lo_q));

  assert_hi_clean_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide_i) |=> (cls_hi_q == CLS_CLEAN));

  logic unused_w;
  assign unused_w = ^BYTE_W;
endmodule

// File: tb/ecc_syndrome_corrector_tb.sv
module ecc_syndrome_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [43:0] calc_code_i = '0;
  logic [43:0] stor_code_i = '0;
  logic        done_o;
  logic [1:0]  cls_lo_o, cls_hi_o;
  logic        err_o;
  logic [8:0]  fix_byte_lo_o, fix_byte_hi_o;
  logic [2:0]  fix_bit_lo_o, fix_bit_hi_o;
  logic [8:0]  rmw_idx_i = '0;
  logic [7:0]  rmw_data_i = '0;
  logic [7:0]  rmw_data_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ecc_syndrome_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .calc_code_i(calc_code_i), .stor_code_i(stor_code_i),
    .done_o(done_o), .cls_lo_o(cls_lo_o), .cls_hi_o(cls_hi_o), .err_o(err_o),
    .fix_byte_lo_o(fix_byte_lo_o), .fix_bit_lo_o(fix_bit_lo_o),
    .fix_byte_hi_o(fix_byte_hi_o), .fix_bit_hi_o(fix_bit_hi_o),
    .rmw_idx_i(rmw_idx_i), .rmw_data_i(rmw_data_i), .rmw_data_o(rmw_data_o)
  );

  localparam logic [21:0] BASE = 22'h2A5C31;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] fix_code(input logic [21:0] s, input logic [10:0] a);
    return s ^ {~a, a};
  endfunction

  task automatic launch(input logic [43:0] c, input logic [43:0] s, input logic w);
    @(negedge clk);
    calc_code_i = c; stor_code_i = s; wide_i = w; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_narrow(input string tag, input logic [21:0] c, input logic [21:0] s,
                            input logic [1:0] ecls, input logic eerr,
                            input logic [8:0] ebyte, input logic [2:0] ebit);
    launch({22'h0, c}, {22'h0, s}, 1'b0);
    chk({tag, " done"}, done_o, 1);
    chk({tag, " class"}, cls_lo_o, ecls);
    chk({tag, " err"}, err_o, eerr);
    chk({tag, " byte"}, fix_byte_lo_o, ebyte);
    chk({tag, " bit"}, fix_bit_lo_o, ebit);
    chk({tag, " R6 hi clean"}, cls_hi_o, 0);
    @(negedge clk);
    chk({tag, " R6 done drops"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 done", done_o, 0);
    chk("R1 lo class", cls_lo_o, 0);
    chk("R1 hi class", cls_hi_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 byte", fix_byte_lo_o, 0);
    rmw_idx_i = 9'h000; rmw_data_i = 8'h5A; #1;
    chk("R1 passthrough", rmw_data_o, 8'h5A);
  endtask

  task automatic t_clean;
    run_narrow("R2 equal", BASE, BASE, 2'b00, 0, 0, 0);
    run_narrow("R2 calc zero", 22'h0, BASE, 2'b00, 0, 0, 0);
    run_narrow("R2 stor zero", BASE, 22'h0, 2'b00, 0, 0, 0);
  endtask

  task automatic t_code_only;
    run_narrow("R3 low bit", BASE ^ 22'h000001, BASE, 2'b01, 1, 0, 0);
    run_narrow("R3 top bit", BASE ^ 22'h200000, BASE, 2'b01, 1, 0, 0);
  endtask

  task automatic t_fix;
    run_narrow("R4 mid", fix_code(BASE, 11'h15B), BASE, 2'b10, 0, 9'h02B, 3'd3);
    run_narrow("R4 addr0", fix_code(BASE, 11'h000), BASE, 2'b10, 0, 9'h000, 3'd0);
    run_narrow("R4 addrmax", fix_code(BASE, 11'h7FF), BASE, 2'b10, 0, 9'h0FF, 3'd7);
    // R9: repair byte 0x0FF bit 7, neighbour untouched
    rmw_idx_i = 9'h0FF; rmw_data_i = 8'h00; #1;
    chk("R9 flip top bit", rmw_data_o, 8'h80);
    rmw_idx_i = 9'h1FF; #1;
    chk("R9 other half passthrough", rmw_data_o, 8'h00);
  endtask

  task automatic t_bad;
    run_narrow("R5 two bits", BASE ^ 22'h000003, BASE, 2'b11, 1, 0, 0);
    // 11 bits set, halves not complementary
    run_narrow("R5 eleven not pair", BASE ^ {11'h002, 11'h7FE}, BASE, 2'b11, 1, 0, 0);
  endtask

  task automatic t_wide;
    logic [21:0] lo_c, hi_c;
    lo_c = BASE;
    hi_c = fix_code(~BASE, 11'h0A2);
    launch({hi_c, lo_c}, {~BASE, BASE}, 1'b1);
    chk("R7 no done yet", done_o, 0);
    chk("R7 lo class early", cls_lo_o, 2'b00);
    @(negedge clk);
    chk("R7 done", done_o, 1);
    chk("R7 lo class held", cls_lo_o, 2'b00);
    chk("R7 hi class", cls_hi_o, 2'b10);
    chk("R7 hi byte +256", fix_byte_hi_o, 9'h114);
    chk("R7 hi bit", fix_bit_hi_o, 3'd2);
    chk("R7 err", err_o, 0);
    rmw_idx_i = 9'h114; rmw_data_i = 8'hF0; #1;
    chk("R9 hi flip", rmw_data_o, 8'hF4);
    rmw_idx_i = 9'h014; #1;
    chk("R9 lo index passthrough", rmw_data_o, 8'hF0);
    @(negedge clk);
    chk("R7 done drops", done_o, 0);
    // error in lower half only: OR reaches err_o
    launch({~BASE, BASE ^ 22'h000010}, {~BASE, BASE}, 1'b1);
    @(negedge clk);
    chk("R7 lo class code", cls_lo_o, 2'b01);
    chk("R7 hi class clean", cls_hi_o, 2'b00);
    chk("R7 err or", err_o, 1);
  endtask

  task automatic t_busy_start;
    @(negedge clk);
    calc_code_i = {~BASE ^ 22'h000003, BASE}; stor_code_i = {~BASE, BASE};
    wide_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    // second start while busy, different codes
    calc_code_i = {fix_code(BASE, 11'h001), BASE ^ 22'h000001};
    stor_code_i = {BASE, BASE};
    wide_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 done from first", done_o, 1);
    chk("R8 lo from first", cls_lo_o, 2'b00);
    chk("R8 hi from first", cls_hi_o, 2'b11);
    @(negedge clk);
    chk("R8 no extra done", done_o, 0);
    chk("R8 lo kept", cls_lo_o, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_code_only();
    t_fix();
    t_bad();
    t_wide();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule